// File: doc/BRIEF.md
# Multi-cycle signed/unsigned integer divider

This unit divides a 32-bit dividend by either a full 32-bit divisor or by the low half of the divisor port. Each operand pair is treated as two's complement or as unsigned, as selected. A one-cycle `start_i` pulse in an idle cycle captures the operands. The unit then stays busy while a restoring radix-2 engine produces one quotient bit per clock. Sign correction and the overflow test follow, and `done_o` pulses for one cycle with the results on the output registers.

A two-bit select chooses whether the quotient, the remainder, both or neither is written. In the narrow (32/16) form both results share one packed word. An oversized narrow quotient raises an overflow flag and leaves the outputs untouched. A zero divisor is not trapped. It raises a status flag, completes in the cycle after the request and also leaves the outputs untouched.

Top module: `int_div`

## Requirements
- R1: After reset `busy_o`, `done_o`, `dbz_o` and `ovf_o` are 0 and `quot_o` and `rem_o` are all zeros.
- R2: With `wide_i`=1 and `signed_i`=0, a completed division writes `quot_o` = floor(dividend/divisor) and `rem_o` = dividend mod divisor, both 32 bits.
- R3: With `signed_i`=1, operands are two's complement, the quotient truncates toward zero and a non-zero remainder carries the sign of the dividend.
- R4: With `wide_i`=0, only `divisor_i[15:0]` is used (sign-extended when signed, zero-extended otherwise). The 16-bit quotient goes to `quot_o[15:0]` and the 16-bit remainder to `quot_o[31:16]`, and `rem_o` is not changed.
- R5: With `wide_i`=0, a quotient outside 0..65535 (unsigned) or outside -32768..32767 (signed) gives `ovf_o`=1 in the done cycle, and neither `quot_o` nor `rem_o` changes. Every non-zero-divisor completion writes `ovf_o` afresh and clears `dbz_o`.
- R6: `sel_i[0]`=1 writes the quotient field and `sel_i[1]`=1 writes the remainder field. An unselected field keeps its previous value.
- R7: A zero effective divisor gives `done_o`=1 and `dbz_o`=1 in the cycle after the accepting edge, with `ovf_o`=0. `busy_o` stays 0, and `quot_o` and `rem_o` are unchanged.
- R8: For a non-zero divisor, `busy_o` is 1 from the cycle after the accepting edge through the 33rd cycle. `done_o` is 1 for exactly the 34th cycle, with `busy_o`=0 in that cycle.
- R9: `start_i` is accepted only when `busy_o`=0. A request while busy is ignored and does not change the running division.
- R10: In 32/32 signed mode, 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; captured when not busy |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor; low half only in narrow form |
| wide_i | input | 1 | 1: 32/32, 0: 32/16 |
| signed_i | input | 1 | 1: two's complement operands |
| sel_i | input | 2 | Bit 0 writes the quotient, bit 1 writes the remainder |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient (wide) or packed remainder:quotient (narrow) |
| rem_o | output | 32 | Remainder (wide form only) |
| dbz_o | output | 1 | Last completion had a zero divisor |
| ovf_o | output | 1 | Last completion overflowed the narrow quotient |

## Verification
The bench targets the signed edges: operands of mixed sign, where floor division instead of truncation would shift the quotient by one and flip the remainder sign, and 0x80000000 / -1, where an unguarded magnitude path corrupts the result. Narrow-form cases sit just inside and just outside the quotient range, including the asymmetric -32768 bound, where a wrong limit either clobbers the outputs or refuses a legal result. A zero low half behind non-zero upper divisor bits, a request issued mid-division, and the select combinations catch designs that read the wrong divisor bits, restart while busy or write fields that were not asked for.

// File: rtl/int_div_pkg.sv
package int_div_pkg;
  typedef struct packed {
    logic       wide;
    logic       sgn;
    logic [1:0] sel;
    logic       neg_q;
    logic       neg_r;
  } div_ctl_t;
endpackage

// File: rtl/int_div_prep.sv
module int_div_prep #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  input  logic          wide_i,
  input  logic          signed_i,
  output logic [DW-1:0] dvd_mag_o,
  output logic [DW-1:0] dvs_mag_o,
  output logic          neg_q_o,
  output logic          neg_r_o,
  output logic          zero_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] dvs_eff;
  logic          dvd_neg, dvs_neg;

  always_comb begin
    if (wide_i) dvs_eff = dvs_i;
    else        dvs_eff = {{HW{signed_i & dvs_i[HW-1]}}, dvs_i[HW-1:0]};
    dvd_neg   = signed_i & dvd_i[DW-1];
    dvs_neg   = signed_i & dvs_eff[DW-1];
    dvd_mag_o = dvd_neg ? (~dvd_i + 1'b1) : dvd_i;
    dvs_mag_o = dvs_neg ? (~dvs_eff + 1'b1) : dvs_eff;
    neg_q_o   = dvd_neg ^ dvs_neg;
    neg_r_o   = dvd_neg;
    zero_o    = (dvs_eff == '0);
  end
endmodule

// File: rtl/int_div_core.sv
module int_div_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          run_o,
  output logic          fin_o
);
  localparam int unsigned CW = $clog2(DW);

  logic [DW:0]   acc_q;
  logic [DW-1:0] quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;

  logic [DW:0] shifted, diff, acc_d;
  logic        ge;

  // restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    shifted = {acc_q[DW-1:0], quo_q[DW-1]};
    diff    = shifted - {1'b0, dvs_q};
    ge      = ~diff[DW];
    acc_d   = ge ? diff : shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (load_i) begin
      acc_q <= '0;
      quo_q <= dvd_i;
      dvs_q <= dvs_i;
      cnt_q <= '0;
      run_q <= 1'b1;
      fin_q <= 1'b0;
    end else if (run_q) begin
      acc_q <= acc_d;
      quo_q <= {quo_q[DW-2:0], ge};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(DW-1)) begin
        run_q <= 1'b0;
        fin_q <= 1'b1;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = acc_q[DW-1:0];
  assign run_o = run_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/int_div_post.sv
module int_div_post #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] quo_mag_i,
  input  logic [DW-1:0] rem_mag_i,
  input  logic          neg_q_i,
  input  logic          neg_r_i,
  input  logic          wide_i,
  input  logic          signed_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          ovf_o
);
  localparam int unsigned HW = DW / 2;
  localparam logic [DW-1:0] POS_LIM = DW'((64'd1 << (HW-1)) - 64'd1);
  localparam logic [DW-1:0] NEG_LIM = DW'(64'd1 << (HW-1));

  always_comb begin
    quo_o = neg_q_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_o = neg_r_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    if (wide_i)        ovf_o = 1'b0;
    else if (signed_i) ovf_o = neg_q_i ? (quo_mag_i > NEG_LIM) : (quo_mag_i > POS_LIM);
    else               ovf_o = |quo_mag_i[DW-1:HW];
  end
endmodule

// File: rtl/int_div.sv
module int_div
  import int_div_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  input  logic          wide_i,
  input  logic          signed_i,
  input  logic [1:0]    sel_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o,
  output logic          dbz_o,
  output logic          ovf_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag, quo_s, rem_s;
  logic          neg_q, neg_r, zero, run, fin, ovf_w, accept, load;
  div_ctl_t      ctl_q;

  logic [DW-1:0] quot_q, rem_q;
  logic          done_q, dbz_q, ovf_q;

  assign accept = start_i & ~run & ~fin;
  assign load   = accept & ~zero;

  int_div_prep #(.DW(DW)) u_prep (
    .dvd_i(dividend_i), .dvs_i(divisor_i), .wide_i(wide_i), .signed_i(signed_i),
    .dvd_mag_o(dvd_mag), .dvs_mag_o(dvs_mag), .neg_q_o(neg_q), .neg_r_o(neg_r),
    .zero_o(zero)
  );

  int_div_core #(.DW(DW)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .dvd_i(dvd_mag), .dvs_i(dvs_mag),
    .quo_o(quo_mag), .rem_o(rem_mag), .run_o(run), .fin_o(fin)
  );

  int_div_post #(.DW(DW)) u_post (
    .quo_mag_i(quo_mag), .rem_mag_i(rem_mag), .neg_q_i(ctl_q.neg_q),
    .neg_r_i(ctl_q.neg_r), .wide_i(ctl_q.wide), .signed_i(ctl_q.sgn),
    .quo_o(quo_s), .rem_o(rem_s), .ovf_o(ovf_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept && zero) begin
        done_q <= 1'b1;
        dbz_q  <= 1'b1;
        ovf_q  <= 1'b0;
      end else if (load) begin
        ctl_q <= '{wide: wide_i, sgn: signed_i, sel: sel_i, neg_q: neg_q, neg_r: neg_r};
      end else if (fin) begin
        done_q <= 1'b1;
        dbz_q  <= 1'b0;
        ovf_q  <= ovf_w;
        if (!ovf_w) begin
          if (ctl_q.wide) begin
            if (ctl_q.sel[0]) quot_q <= quo_s;
            if (ctl_q.sel[1]) rem_q  <= rem_s;
          end else begin
            if (ctl_q.sel[0]) quot_q[HW-1:0]  <= quo_s[HW-1:0];
            if (ctl_q.sel[1]) quot_q[DW-1:HW] <= rem_s[HW-1:0];
          end
        end
      end
    end
  end

  assign busy_o = run | fin;
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = rem_q;
  assign dbz_o  = dbz_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/int_div_chk.sv
module int_div_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] quot_o,
  input logic [DW-1:0] rem_o,
  input logic          dbz_o,
  input logic          ovf_o
);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_busy_excl_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  a_r7_dbz_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbz_o) |-> (done_o && !ovf_o));

  a_r5_no_write_on_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ovf_o || dbz_o)) |-> ($stable(quot_o) && $stable(rem_o)));

  a_r6_write_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(quot_o) || !$stable(rem_o)) |-> done_o);
endmodule

bind int_div int_div_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .quot_o(quot_o), .rem_o(rem_o), .dbz_o(dbz_o), .ovf_o(ovf_o)
);

// File: tb/int_div_tb.sv
module int_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dvd = '0, dvs = '0;
  logic        wide = 1'b1, sgn = 1'b0;
  logic [1:0]  sel = 2'b11;
  logic        busy, done, dbz, ovf;
  logic [31:0] quot, rem;

  int n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  int_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dividend_i(dvd), .divisor_i(dvs),
    .wide_i(wide), .signed_i(sgn), .sel_i(sel), .busy_o(busy), .done_o(done),
    .quot_o(quot), .rem_o(rem), .dbz_o(dbz), .ovf_o(ovf)
  );

  // behavioural reference
  logic        m_busy, m_done, m_dbz, m_ovf;
  logic [31:0] m_quot, m_rem;
  int          m_cnt;
  logic [31:0] p_q, p_r;
  logic        p_ovf, p_wide;
  logic [1:0]  p_sel;
  string       tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dbz = 0; m_ovf = 0; m_quot = 0; m_rem = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          longint a, b, q, r;
          a = sgn ? longint'($signed(dvd)) : longint'(dvd);
          if (wide) b = sgn ? longint'($signed(dvs)) : longint'(dvs);
          else      b = sgn ? longint'($signed(dvs[15:0])) : longint'(dvs[15:0]);
          if (b == 0) begin
            m_done = 1; m_dbz = 1; m_ovf = 0;
          end else begin
            q = a / b; r = a % b;
            p_q = q[31:0]; p_r = r[31:0];
            p_ovf = !wide && (sgn ? (q > 32767 || q < -32768) : (q > 65535));
            p_wide = wide; p_sel = sel;
            m_busy = 1; m_cnt = 33;
          end
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_dbz = 0; m_ovf = p_ovf;
          if (!p_ovf) begin
            if (p_wide) begin
              if (p_sel[0]) m_quot = p_q;
              if (p_sel[1]) m_rem = p_r;
            end else begin
              if (p_sel[0]) m_quot[15:0] = p_q[15:0];
              if (p_sel[1]) m_quot[31:16] = p_r[15:0];
            end
          end
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("busy_o", 32'(busy), 32'(m_busy));
    chk("done_o", 32'(done), 32'(m_done));
    chk("dbz_o",  32'(dbz),  32'(m_dbz));
    chk("ovf_o",  32'(ovf),  32'(m_ovf));
    chk("quot_o", quot, m_quot);
    chk("rem_o",  rem,  m_rem);
  end

  task automatic op(string t, logic [31:0] a, logic [31:0] b, logic w, logic s, logic [1:0] se);
    tag = t;
    @(posedge clk); #2;
    dvd = a; dvs = b; wide = w; sgn = s; sel = se; start = 1;
    @(posedge clk); #2;
    start = 0;
    while (m_busy) begin @(posedge clk); #2; end
    @(posedge clk); #2;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk); // R1 reset state checked by per-cycle compare
    // R2 unsigned wide
    op("R2", 32'd1000, 32'd7, 1, 0, 2'b11);
    op("R2", 32'hFFFFFFFF, 32'h00010001, 1, 0, 2'b11);
    op("R2", 32'd5, 32'd9, 1, 0, 2'b11);
    // R3 signed truncation, remainder sign follows dividend
    op("R3", -32'sd7, 32'd2, 1, 1, 2'b11);
    op("R3", 32'd7, -32'sd2, 1, 1, 2'b11);
    op("R3", -32'sd7, -32'sd2, 1, 1, 2'b11);
    // R10 most negative / -1
    op("R10", 32'h80000000, 32'hFFFFFFFF, 1, 1, 2'b11);
    // R4 narrow packing, upper divisor bits ignored, rem_o untouched
    op("R4", 32'd100000, 32'hABCD0007, 0, 0, 2'b11);
    op("R4", -32'sd1000, 32'h0000FFF9, 0, 1, 2'b11);
    // R5 narrow overflow bounds
    op("R5", 32'd65535, 32'd1, 0, 0, 2'b11);
    op("R5", 32'd65536, 32'd1, 0, 0, 2'b11);
    op("R5", 32'd32768, 32'h0000FFFF, 0, 1, 2'b11);
    op("R5", 32'd32768, 32'd1, 0, 1, 2'b11);
    op("R5", 32'd32767, 32'd1, 0, 1, 2'b11);
    // R6 selects
    op("R6", 32'd77, 32'd10, 1, 0, 2'b01);
    op("R6", 32'd99, 32'd10, 1, 0, 2'b10);
    op("R6", 32'd55, 32'd4, 1, 0, 2'b00);
    op("R6", 32'd300, 32'd7, 0, 0, 2'b10);
    // R7 divide by zero, including zero low half in narrow form
    op("R7", 32'd123, 32'd0, 1, 0, 2'b11);
    op("R7", 32'd123, 32'hFFFF0000, 0, 1, 2'b11);
    op("R7", 32'd123, 32'd0, 1, 1, 2'b11);
    // R9 request while busy ignored; R8 latency checked throughout
    tag = "R9";
    @(posedge clk); #2;
    dvd = 32'd5000; dvs = 32'd3; wide = 1; sgn = 0; sel = 2'b11; start = 1;
    @(posedge clk); #2; start = 0;
    repeat (5) @(posedge clk); #2;
    dvd = 32'd9; dvs = 32'd0; start = 1;
    @(posedge clk); #2;
    dvd = 32'd1; dvs = 32'd1; wide = 0; sel = 2'b00;
    @(posedge clk); #2; start = 0;
    while (m_busy) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    // R8 back-to-back and random mix
    for (int i = 0; i < 150; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 3 == 0) b = b >> (b[4:0]);
      op("R8", a, b, 1'($urandom), 1'($urandom), 2'($urandom));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule